// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single timer channel with a 32-bit register interface. Software programs an interval, chooses a tick source and a power-of-two prescale ratio, and selects continuous or single-shot operation. Then it sets the channel enable. The counter decrements once per prescaled tick. When the counter expires, the block latches a pending flag. In continuous operation the counter refills from the interval register. In single-shot operation the counter parks at zero and the channel disables itself.

The tick sources are clock-enable inputs that come from elsewhere on the chip. The block never generates a clock. Software can load the counter in two ways: it can write the count register directly, or it can write the control register with its reload bit set. The interrupt line is the pending flag qualified by a global enable bit. Software acknowledges an interrupt by writing a one to the status register.

Top module: `mmio_tick_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq` is low.
- R2: The register offsets are 0x00 global interrupt enable (bit 0), 0x04 status (bit 0 pending), 0x10 control, 0x14 interval and 0x18 count. The control fields are: bit 0 enable, bit 1 reload, [3:2] source select, [6:4] prescale exponent, bit 7 single-shot (0 = continuous). Written fields read back.
- R3: Writing control with bit 1 set copies the interval into the counter and restarts the prescaler. The reload bit reads back as zero from the second cycle after the write.
- R4: While the channel is enabled, the counter decreases by one per prescaled tick. A tick that arrives while the count is 1 (or 0) is an expiry, so a count of N expires on the Nth tick.
- R5: In continuous mode, an expiry reloads the counter from the interval register.
- R6: In single-shot mode, an expiry leaves the count at zero and clears the control enable bit.
- R7: The prescaler passes one tick out of every 2^field source ticks.
- R8: Source select 0 takes `src_tick[0]` and 1 takes `src_tick[1]`. Any value at or above NSRC gives no ticks.
- R9: Clearing the enable bit freezes the count and the prescaler. Setting it again resumes from the held count.
- R10: A write to the count register loads that value directly. Enabling the channel without reload then counts from the loaded value.
- R11: The pending flag is sticky. Writing 1 to status bit 0 clears it, but an expiry in the same cycle keeps it set.
- R12: `irq` is high exactly when the pending flag and global enable bit 0 are both set.
- R13: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| src_tick | input | NSRC | Tick-enable inputs, one per source |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, 8-bit offsets and two tick sources. It then programs very small intervals (1 to 20). Those short intervals keep every expiry, reload and single-shot stop within a few dozen cycles. With source 1 held high, the prescaled tick becomes an exact cycle count, so prescale exponents 0 and 2 give exact expiry cycles. Source select 2, which is at or above NSRC, exercises the no-tick path.

// File: rtl/tmr_pkg.sv
// Shared constants and control-register layout for the interval timer.
// Assumes a 32-bit data bus and byte offsets.
package tmr_pkg;
    localparam int DATA_W   = 32;
    localparam int PRE_W    = 3;                    // prescale exponent field width
    localparam int DIV_W    = (1 << PRE_W) - 1;     // prescaler counter width

    localparam int OFS_GIE  = 'h00;
    localparam int OFS_STAT = 'h04;
    localparam int OFS_CTRL = 'h10;
    localparam int OFS_IVAL = 'h14;
    localparam int OFS_CNT  = 'h18;

    // Bit order matters: bit 7 single-shot, [6:4] prescale, [3:2] source, 1 reload, 0 enable
    typedef struct packed {
        logic             oneshot;
        logic [PRE_W-1:0] presc;
        logic [1:0]       src;
        logic             reload;
        logic             en;
    } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
// Register file: decodes writes, holds global enable, control and interval,
// and muxes read data. Assumes single-cycle write strobes.
module tmr_regs #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [tmr_pkg::DATA_W-1:0] bus_wdata,
    output logic [tmr_pkg::DATA_W-1:0] bus_rdata,
    input  logic                       stop,
    input  logic                       pend_q,
    input  logic [CNT_W-1:0]           count_q,
    output logic                       gie_q,
    output tmr_pkg::ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]           interval_q,
    output logic                       cnt_wr,
    output logic                       clr_req,
    output logic                       reload_req
);
    import tmr_pkg::*;

    logic wr_gie, wr_stat, wr_ctrl, wr_ival;

    // Address decode of write strobes
    always_comb begin
        wr_gie     = bus_wr && (bus_addr == ADDR_W'(OFS_GIE));
        wr_stat    = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
        wr_ctrl    = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_ival    = bus_wr && (bus_addr == ADDR_W'(OFS_IVAL));
        cnt_wr     = bus_wr && (bus_addr == ADDR_W'(OFS_CNT));
        clr_req    = wr_stat && bus_wdata[0];
        reload_req = wr_ctrl && bus_wdata[1];
    end

    // Global interrupt enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)      gie_q <= 1'b0;
        else if (wr_gie) gie_q <= bus_wdata[0];
    end

    // Control register; reload self-clears, single-shot expiry drops enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(bus_wdata[7:0]);
        end else begin
            ctrl_q.reload <= 1'b0;
            if (stop) ctrl_q.en <= 1'b0;
        end
    end

    // Interval register
    always_ff @(posedge clk) begin
        if (!rst_n)       interval_q <= '0;
        else if (wr_ival) interval_q <= bus_wdata[CNT_W-1:0];
    end

    // Read data mux; unmapped offsets read zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_GIE):  bus_rdata = DATA_W'(gie_q);
            ADDR_W'(OFS_STAT): bus_rdata = DATA_W'(pend_q);
            ADDR_W'(OFS_CTRL): bus_rdata = DATA_W'(ctrl_q);
            ADDR_W'(OFS_IVAL): bus_rdata = DATA_W'(interval_q);
            ADDR_W'(OFS_CNT):  bus_rdata = DATA_W'(count_q);
            default:           bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_prescale.sv
// Tick selector and power-of-two prescaler. One free-running counter is
// compared under a mask, so any exponent uses the same storage. Assumes
// the source select field is 2 bits wide and NSRC <= 4.
module tmr_prescale #(
    parameter int NSRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           src_tick,
    input  logic [1:0]                src_sel,
    input  logic [tmr_pkg::PRE_W-1:0] presc,
    input  logic                      run,
    input  logic                      restart,
    output logic                      ptick
);
    import tmr_pkg::*;

    logic             sel_tick;
    logic             at_wrap;
    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] mask;

    // Pick the selected tick source; out-of-range selections give none
    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < NSRC; i++)
            if (src_sel == 2'(i)) sel_tick = src_tick[i];
    end

    // Wrap mask (2^presc - 1) and prescaled tick generation
    always_comb begin
        mask    = ~({DIV_W{1'b1}} << presc);
        at_wrap = run && sel_tick && ((pcnt & mask) == mask);
        ptick   = at_wrap && !restart;
    end

    // Prescaler counter: restarts on reload, holds while not running
    always_ff @(posedge clk) begin
        if (!rst_n)                pcnt <= '0;
        else if (restart)          pcnt <= '0;
        else if (run && sel_tick)  pcnt <= at_wrap ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/tmr_count.sv
// Down counter with direct load, reload from interval and expiry detection.
// Assumes load and reload never occur in the same cycle (different offsets).
module tmr_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptick,
    input  logic             oneshot,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             reload,
    input  logic [CNT_W-1:0] interval,
    output logic [CNT_W-1:0] count_q,
    output logic             expire
);
    // Expiry: a tick while the count is at 1 or 0, unless software overrides it
    always_comb expire = ptick && (count_q <= CNT_W'(1)) && !load && !reload;

    // Count register update in priority order
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (load)   count_q <= load_val;
        else if (reload) count_q <= interval;
        else if (expire) count_q <= oneshot ? '0 : interval;
        else if (ptick)  count_q <= count_q - 1'b1;
    end
endmodule

// File: rtl/tmr_pend.sv
// Sticky pending flag with write-one-to-clear and gated interrupt output.
// Assumes set has priority over clear.
module tmr_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic gie,
    output logic pend_q,
    output logic irq
);
    // Pending flag: set wins over a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= set || (pend_q && !clr);
    end

    // Interrupt qualified by the global enable
    always_comb irq = pend_q && gie;
endmodule

// File: rtl/mmio_tick_timer.sv
// Top level of the single-channel interval timer. It wires the register
// file, the prescaler, the counter and the pending logic together.
// Assumes tick sources are clock enables synchronous to clk.
module mmio_tick_timer #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int NSRC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NSRC-1:0]   src_tick,
    output logic              irq
);
    import tmr_pkg::*;

    ctrl_t            ctrl_q;
    logic             gie_q, pend_q, cnt_wr, clr_req, reload_req;
    logic             ptick, expire, stop, en_q, oneshot_q;
    logic [CNT_W-1:0] interval_q, count_q;

    // Single-shot expiry request and flattened control bits
    always_comb begin
        stop      = expire && ctrl_q.oneshot;
        en_q      = ctrl_q.en;
        oneshot_q = ctrl_q.oneshot;
    end

    tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stop(stop),
        .pend_q(pend_q), .count_q(count_q), .gie_q(gie_q), .ctrl_q(ctrl_q),
        .interval_q(interval_q), .cnt_wr(cnt_wr), .clr_req(clr_req),
        .reload_req(reload_req)
    );

    tmr_prescale #(.NSRC(NSRC)) u_pre (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_sel(ctrl_q.src),
        .presc(ctrl_q.presc), .run(en_q), .restart(reload_req), .ptick(ptick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ptick(ptick), .oneshot(oneshot_q),
        .load(cnt_wr), .load_val(bus_wdata[CNT_W-1:0]), .reload(reload_req),
        .interval(interval_q), .count_q(count_q), .expire(expire)
    );

    tmr_pend u_pend (
        .clk(clk), .rst_n(rst_n), .set(expire), .clr(clr_req), .gie(gie_q),
        .pend_q(pend_q), .irq(irq)
    );
endmodule

// File: rtl/tmr_checker.sv
// Temporal checks on the timer, attached to every instance by bind.
module tmr_checker #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq,
    input logic              pend,
    input logic              en,
    input logic              oneshot,
    input logic              expire,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  interval
);
    logic clr_wr;
    always_comb clr_wr = bus_wr && (bus_addr == ADDR_W'('h04)) && bus_wdata[0];

    assert_expire_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend);

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !clr_wr |=> pend);

    assert_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pend && clr_wr && !expire |=> !pend);

    assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !oneshot && !bus_wr |=> count == $past(interval));

    assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire && oneshot && !bus_wr |=> !en && count == '0);

    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !bus_wr |=> $stable(count));

    assert_irq_needs_pend_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend);
endmodule

bind mmio_tick_timer tmr_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq(irq), .pend(pend_q), .en(en_q),
    .oneshot(oneshot_q), .expire(expire), .count(count_q), .interval(interval_q)
);

// File: tb/tb_mmio_tick_timer.sv
// Directed bench for the interval timer: one task per scenario.
module tb_mmio_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  src_tick = 2'b10;
    logic        irq;
    int          total = 0;
    int          fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    mmio_tick_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Cycles (edges) until irq rises; -1 if it never does
    task automatic wait_irq(input int maxc, output int n);
        n = -1;
        for (int i = 1; i <= maxc; i++) begin
            @(negedge clk);
            if (irq) begin n = i; break; end
        end
    endtask

    task automatic idle_off();
        wr(8'h10, 32'h0);
        wr(8'h04, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); chk("R1 gie", d, 0);
        rd(8'h04, d); chk("R1 status", d, 0);
        rd(8'h10, d); chk("R1 ctrl", d, 0);
        rd(8'h14, d); chk("R1 interval", d, 0);
        rd(8'h18, d); chk("R1 count", d, 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h08, d); chk("R13 read 08", d, 0);
        rd(8'h1C, d); chk("R13 read 1C", d, 0);
        rd(8'h00, d); chk("R13 gie untouched", d, 0);
        rd(8'h10, d); chk("R13 ctrl untouched", d, 0);
        rd(8'h14, d); chk("R13 interval untouched", d, 0);
    endtask

    task automatic t_periodic();
        logic [31:0] d; int n;
        wr(8'h00, 32'h1);
        wr(8'h14, 32'd5);
        rd(8'h14, d); chk("R2 interval readback", d, 5);
        wr(8'h10, 32'h07);             // en, reload, source 1, /1, continuous
        wait_irq(20, n);
        chk("R4 expiry after 5 ticks", 32'(n), 5);
        rd(8'h18, d); chk("R5 reloaded count", d, 5);
        rd(8'h10, d); chk("R3 reload self-clear", d, 32'h05);
        wr(8'h04, 32'h1);
        chk("R11 w1c clears irq", 32'(irq), 0);
        idle_off();
    endtask

    task automatic t_oneshot();
        logic [31:0] d; int n;
        wr(8'h14, 32'd3);
        wr(8'h10, 32'h87);             // single-shot
        wait_irq(20, n);
        chk("R6 single-shot expiry", 32'(n), 3);
        rd(8'h10, d); chk("R6 enable cleared", d, 32'h84);
        rd(8'h18, d); chk("R6 count at zero", d, 0);
        wr(8'h04, 32'h1);
        repeat (6) @(negedge clk);
        chk("R6 no further expiry", 32'(irq), 0);
        rd(8'h18, d); chk("R6 count holds zero", d, 0);
        idle_off();
    endtask

    task automatic t_prescale();
        int n;
        wr(8'h14, 32'd2);
        wr(8'h10, 32'h27);             // exponent 2 -> divide by 4
        wait_irq(30, n);
        chk("R7 divide by 4, two ticks", 32'(n), 8);
        idle_off();
        wr(8'h14, 32'd1);
        wr(8'h10, 32'h37);             // exponent 3 -> divide by 8
        wait_irq(30, n);
        chk("R7 divide by 8, one tick", 32'(n), 8);
        idle_off();
    endtask

    task automatic t_source();
        logic [31:0] d; int n;
        wr(8'h14, 32'd4);
        wr(8'h10, 32'h03);             // source 0, held low
        repeat (10) @(negedge clk);
        rd(8'h18, d); chk("R8 source 0 idle", d, 4);
        src_tick[0] = 1'b1;
        wait_irq(20, n);
        chk("R8 source 0 ticking", 32'(n), 4);
        idle_off();
        src_tick[0] = 1'b0;
        wr(8'h10, 32'h0B);             // source 2: no tick
        repeat (10) @(negedge clk);
        rd(8'h18, d); chk("R8 source 2 gives no tick", d, 4);
        idle_off();
    endtask

    task automatic t_freeze();
        logic [31:0] d; int n;
        wr(8'h14, 32'd20);
        wr(8'h10, 32'h07);
        repeat (3) @(negedge clk);
        wr(8'h10, 32'h04);             // drop enable
        rd(8'h18, d); chk("R9 count at disable", d, 15);
        repeat (5) @(negedge clk);
        rd(8'h18, d); chk("R9 count frozen", d, 15);
        wr(8'h10, 32'h05);             // resume without reload
        wait_irq(40, n);
        chk("R9 resumes from held count", 32'(n), 15);
        idle_off();
    endtask

    task automatic t_direct();
        logic [31:0] d; int n;
        wr(8'h14, 32'd9);
        wr(8'h18, 32'd2);
        rd(8'h18, d); chk("R10 count written", d, 2);
        wr(8'h10, 32'h05);
        wait_irq(20, n);
        chk("R10 expiry from loaded count", 32'(n), 2);
        rd(8'h18, d); chk("R5 reload after direct load", d, 9);
        idle_off();
    endtask

    task automatic t_gate();
        logic [31:0] d; int n;
        wr(8'h00, 32'h0);
        wr(8'h14, 32'd1);
        wr(8'h10, 32'h87);
        repeat (4) @(negedge clk);
        chk("R12 irq masked", 32'(irq), 0);
        rd(8'h04, d); chk("R12 pending while masked", d, 1);
        wr(8'h00, 32'h1);
        chk("R12 irq after enable", 32'(irq), 1);
        idle_off();
        n = 0;
    endtask

    task automatic t_setwins();
        logic [31:0] d;
        wr(8'h14, 32'd1);
        wr(8'h10, 32'h07);             // expires on every tick
        repeat (2) @(negedge clk);
        wr(8'h04, 32'h1);
        rd(8'h04, d); chk("R11 expiry beats clear", d, 1);
        idle_off();
        rd(8'h04, d); chk("R11 clear when idle", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unmapped();
        t_periodic();
        t_oneshot();
        t_prescale();
        t_source();
        t_freeze();
        t_direct();
        t_gate();
        t_setwins();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #1_000_000;
        total++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule